// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status byte of a small accumulator-style CPU. It holds five live bits: a half-carry flag, an interrupt mask, and the negative, zero and carry flags. The three top bits are tied high. On each clock it takes the ALU result and carry information for the current instruction class, together with explicit flag commands, interrupt entry and pop/return strobes. It then computes the next flag values under a fixed priority.

Conditional-branch logic reads the individual flag outputs. The stack path reads the whole byte for a push and writes it back through the pop bus. Maskable interrupt requests are latched as pending and are forwarded only while the mask is clear. A trap request is forwarded at all times. The external reset is asserted asynchronously, and a two-stage synchronizer releases it on a clock edge.

Top module: `status_flag_reg`

## Requirements
- R1: `ccr_q` packs the flags as bit 4 half-carry, bit 3 mask, bit 2 negative, bit 1 zero, bit 0 carry, and bits 7..5 always read 1.
- R2: While reset is active, and after it is released, `ccr_q` reads 0xE8 (mask set, other flags 0), and `irq_pending` and `irq_out` (with no trap) read 0.
- R3: Half-carry takes `alu_hc` only for op class 1 (add / add-with-carry). Every other class leaves it unchanged.
- R4: For op classes 1 (add), 2 (subtract), 3 (logic), 4 (shift/rotate) and 6 (data move), negative takes result bit 7 and zero is set exactly when the result is 0x00. Classes 0, 5 and 7 leave both unchanged.
- R5: For op classes 1, 2, 4 and 5 (bit test), carry takes `alu_cout`. Classes 0, 3, 6 and 7 leave it unchanged.
- R6: `set_c` forces carry to 1, and `clr_c` forces it to 0. `set_c` wins over `clr_c`, and both win over any ALU update of carry.
- R7: The mask becomes 1 on `irq_enter` or `set_m`, and becomes 0 on `clr_m`. `irq_enter` and `set_m` win over `clr_m`.
- R8: An `irq_req` pulse sets the pending latch whatever the mask is. `irq_out` is high whenever the latch is set and the mask is clear, including when the mask is cleared later.
- R9: `trap_req` drives `irq_out` high in the same cycle regardless of the mask.
- R10: `pop_load` loads bits 4..0 of `pop_data` into all five flags, mask included, and takes priority over every other update source in that cycle.
- R11: `irq_enter` clears the pending latch, even when `irq_req` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_cls | input | 3 | Instruction class: 0 none, 1 add, 2 sub, 3 logic, 4 shift, 5 bit test, 6 move, 7 none |
| alu_res | input | 8 | ALU result |
| alu_cout | input | 1 | Carry / borrow / tested bit from ALU |
| alu_hc | input | 1 | Carry out of bit 3 |
| set_c | input | 1 | Force carry to 1 |
| clr_c | input | 1 | Force carry to 0 |
| set_m | input | 1 | Set interrupt mask |
| clr_m | input | 1 | Clear interrupt mask |
| irq_enter | input | 1 | Interrupt entry acknowledge |
| pop_load | input | 1 | Load register from pop bus (pop or interrupt return) |
| pop_data | input | 8 | Popped status byte |
| irq_req | input | 1 | Maskable interrupt request |
| trap_req | input | 1 | Software trap request |
| ccr_q | output | 8 | Full status byte |
| flag_h | output | 1 | Half-carry |
| flag_i | output | 1 | Interrupt mask |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_c | output | 1 | Carry |
| irq_pending | output | 1 | Pending latch |
| irq_out | output | 1 | Interrupt request to sequencer |

## Verification
Every flag has its own output pin, so a wrong next-state choice appears at the ports one clock after the stimulus that caused it. Examples are a wrong op-class enable, a lost priority or a stale pending latch. The bench sweeps every op class against all 256 results and all carry/half-carry pairs, and compares all flags after every cycle. A flag that should have held its value but moved is therefore seen on the first instruction of a class that does not own it. The mask and pending paths are checked through `irq_out` in the same cycle as the state they depend on.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int CCR_W = 8;
  localparam int FB_C  = 0;
  localparam int FB_Z  = 1;
  localparam int FB_N  = 2;
  localparam int FB_I  = 3;
  localparam int FB_H  = 4;
  localparam int FB_HI = FB_H + 1;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ADD   = 3'd1,
    OP_SUB   = 3'd2,
    OP_LOGIC = 3'd3,
    OP_SHIFT = 3'd4,
    OP_BTEST = 3'd5,
    OP_MOVE  = 3'd6,
    OP_RSVD  = 3'd7
  } op_cls_e;

  typedef struct packed {
    logic h;
    logic n;
    logic z;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/ccr_alu_upd.sv
module ccr_alu_upd
  import flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_cls,
  input  logic [W-1:0] alu_res,
  input  logic         alu_cout,
  input  logic         alu_hc,
  output logic         en_h,
  output logic         en_nz,
  output logic         en_c,
  output alu_flags_t   val
);
  op_cls_e op;

  always_comb begin
    op    = op_cls_e'(op_cls);
    en_h  = 1'b0;
    en_nz = 1'b0;
    en_c  = 1'b0;
    unique case (op)
      OP_ADD:   begin en_h = 1'b1; en_nz = 1'b1; en_c = 1'b1; end
      OP_SUB:   begin en_nz = 1'b1; en_c = 1'b1; end
      OP_LOGIC: begin en_nz = 1'b1; end
      OP_SHIFT: begin en_nz = 1'b1; en_c = 1'b1; end
      OP_BTEST: begin en_c = 1'b1; end
      OP_MOVE:  begin en_nz = 1'b1; end
      default:  begin end
    endcase
    val.h = alu_hc;
    val.n = alu_res[W-1];
    val.z = (alu_res == '0);
    val.c = alu_cout;
  end
endmodule

// File: rtl/ccr_mask_ctl.sv
module ccr_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_load,
  input  logic pop_mask,
  input  logic irq_enter,
  input  logic set_m,
  input  logic clr_m,
  input  logic irq_req,
  input  logic trap_req,
  output logic mask_q,
  output logic pend_q,
  output logic irq_out
);
  logic mask_d, mask_en;
  logic pend_d, pend_en;

  always_comb begin
    mask_en = pop_load | irq_enter | set_m | clr_m;
    mask_d  = mask_q;
    if (pop_load)               mask_d = pop_mask;
    else if (irq_enter | set_m) mask_d = 1'b1;
    else if (clr_m)             mask_d = 1'b0;
    pend_en = irq_req | irq_enter;
    pend_d  = (pend_q | irq_req) & ~irq_enter;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign irq_out = (pend_q & ~mask_q) | trap_req;

  a_r7_enter_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enter && !pop_load) |=> mask_q);
  a_r7_clear_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_m && !set_m && !irq_enter && !pop_load) |=> !mask_q);
  a_r8_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_enter) |=> pend_q);
  a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_enter |=> !pend_q);
  a_r9_trap_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> irq_out);
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import flag_pkg::*;
#(
  parameter int W          = CCR_W,
  parameter int SYNC_STAGE = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_cls,
  input  logic [W-1:0] alu_res,
  input  logic         alu_cout,
  input  logic         alu_hc,
  input  logic         set_c,
  input  logic         clr_c,
  input  logic         set_m,
  input  logic         clr_m,
  input  logic         irq_enter,
  input  logic         pop_load,
  input  logic [W-1:0] pop_data,
  input  logic         irq_req,
  input  logic         trap_req,
  output logic [W-1:0] ccr_q,
  output logic         flag_h,
  output logic         flag_i,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         irq_pending,
  output logic         irq_out
);
  localparam int PAD_W = W - FB_HI;

  logic       rst_s_n;
  logic       en_h, en_nz, en_c;
  alu_flags_t alu_v;
  alu_flags_t fl_q, fl_d;
  logic       fl_en;
  logic       mask_q;
  logic       unused_pop;

  rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  ccr_alu_upd #(.W(W)) u_alu (
    .op_cls   (op_cls),
    .alu_res  (alu_res),
    .alu_cout (alu_cout),
    .alu_hc   (alu_hc),
    .en_h     (en_h),
    .en_nz    (en_nz),
    .en_c     (en_c),
    .val      (alu_v)
  );

  ccr_mask_ctl u_mask (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .pop_load  (pop_load),
    .pop_mask  (pop_data[FB_I]),
    .irq_enter (irq_enter),
    .set_m     (set_m),
    .clr_m     (clr_m),
    .irq_req   (irq_req),
    .trap_req  (trap_req),
    .mask_q    (mask_q),
    .pend_q    (irq_pending),
    .irq_out   (irq_out)
  );

  always_comb begin
    fl_d  = fl_q;
    fl_en = pop_load | set_c | clr_c | en_h | en_nz | en_c;
    if (pop_load) begin
      fl_d.h = pop_data[FB_H];
      fl_d.n = pop_data[FB_N];
      fl_d.z = pop_data[FB_Z];
      fl_d.c = pop_data[FB_C];
    end else begin
      if (en_h) fl_d.h = alu_v.h;
      if (en_nz) begin
        fl_d.n = alu_v.n;
        fl_d.z = alu_v.z;
      end
      if (set_c)      fl_d.c = 1'b1;
      else if (clr_c) fl_d.c = 1'b0;
      else if (en_c)  fl_d.c = alu_v.c;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) fl_q <= '0;
    else if (fl_en) fl_q <= fl_d;
  end

  assign unused_pop = ^pop_data[W-1:FB_HI];

  assign flag_h = fl_q.h;
  assign flag_i = mask_q;
  assign flag_n = fl_q.n;
  assign flag_z = fl_q.z;
  assign flag_c = fl_q.c;
  assign ccr_q  = {{PAD_W{1'b1}}, fl_q.h, mask_q, fl_q.n, fl_q.z, fl_q.c};

  a_r10_pop_loads: assert property (@(posedge clk) disable iff (!rst_s_n)
    pop_load |=> (ccr_q[FB_H:0] == $past(pop_data[FB_H:0])));
  a_r3_h_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!pop_load && op_cls != 3'd1) |=> $stable(flag_h));
  a_r6_set_carry: assert property (@(posedge clk) disable iff (!rst_s_n)
    (set_c && !pop_load) |=> flag_c);
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!pop_load && op_cls == 3'd6) |=> (flag_z == ($past(alu_res) == '0)));
  a_r1_fields: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ccr_q[FB_I] == flag_i) && (ccr_q[FB_C] == flag_c));
endmodule

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_cls;
  logic [7:0] alu_res, pop_data, ccr_q;
  logic       alu_cout, alu_hc, set_c, clr_c, set_m, clr_m;
  logic       irq_enter, pop_load, irq_req, trap_req;
  logic       flag_h, flag_i, flag_n, flag_z, flag_c, irq_pending, irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic m_h, m_i, m_n, m_z, m_c, m_p;

  always #5 clk = ~clk;

  status_flag_reg u_dut (
    .clk(clk), .rst_n(rst_n), .op_cls(op_cls), .alu_res(alu_res),
    .alu_cout(alu_cout), .alu_hc(alu_hc), .set_c(set_c), .clr_c(clr_c),
    .set_m(set_m), .clr_m(clr_m), .irq_enter(irq_enter), .pop_load(pop_load),
    .pop_data(pop_data), .irq_req(irq_req), .trap_req(trap_req),
    .ccr_q(ccr_q), .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .irq_pending(irq_pending), .irq_out(irq_out)
  );

  task automatic idle();
    op_cls = 3'd0; alu_res = 8'h00; alu_cout = 1'b0; alu_hc = 1'b0;
    set_c = 1'b0; clr_c = 1'b0; set_m = 1'b0; clr_m = 1'b0;
    irq_enter = 1'b0; pop_load = 1'b0; pop_data = 8'h00;
    irq_req = 1'b0; trap_req = 1'b0;
  endtask

  task automatic model_update();
    if (pop_load) begin
      m_h = pop_data[4]; m_i = pop_data[3]; m_n = pop_data[2];
      m_z = pop_data[1]; m_c = pop_data[0];
    end else begin
      if (irq_enter || set_m) m_i = 1'b1;
      else if (clr_m)         m_i = 1'b0;
      if (op_cls == 3'd1) m_h = alu_hc;
      if (op_cls inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6}) begin
        m_n = alu_res[7];
        m_z = (alu_res == 8'h00);
      end
      if (set_c)      m_c = 1'b1;
      else if (clr_c) m_c = 1'b0;
      else if (op_cls inside {3'd1, 3'd2, 3'd4, 3'd5}) m_c = alu_cout;
    end
    m_p = (m_p | irq_req) & ~irq_enter;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, ccr_q, {3'b111, m_h, m_i, m_n, m_z, m_c});
    chk(tag, {6'd0, irq_pending, irq_out}, {6'd0, m_p, (m_p & ~m_i) | trap_req});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    m_h = 0; m_i = 1; m_n = 0; m_z = 0; m_c = 0; m_p = 0;
    repeat (3) @(negedge clk);
    chk_all("R2 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R2 after release");
    chk("R1 upper bits", {5'd0, ccr_q[7:5]}, 8'h07);

    // R3 R4 R5: sweep every op class, result, carry and half-carry
    for (int op = 0; op < 8; op++) begin
      for (int r = 0; r < 256; r++) begin
        for (int k = 0; k < 4; k++) begin
          op_cls = op[2:0]; alu_res = r[7:0];
          alu_cout = k[0]; alu_hc = k[1];
          cyc();
          chk($sformatf("R3 R4 R5 op=%0d", op), ccr_q, {3'b111, m_h, m_i, m_n, m_z, m_c});
          chk("R1 flag pins", {3'b111, flag_h, flag_i, flag_n, flag_z, flag_c}, ccr_q);
        end
      end
    end
    idle();

    // R3: 0x0F + 0x01 gives a half carry
    op_cls = 3'd1; alu_res = 8'h10; alu_hc = 1'b1; alu_cout = 1'b0;
    cyc();
    chk("R3 0F+01", ccr_q, 8'hF8);
    // R4 R5: 0xFF + 0x01 gives zero and carry
    op_cls = 3'd1; alu_res = 8'h00; alu_hc = 1'b1; alu_cout = 1'b1;
    cyc();
    chk("R4 R5 FF+01", ccr_q, 8'hFB);
    idle();

    // R6: carry commands against ALU carry
    for (int k = 0; k < 32; k++) begin
      op_cls = 3'd1; alu_res = 8'h01; alu_cout = k[0]; alu_hc = 1'b0;
      set_c = k[1]; clr_c = k[2];
      cyc();
      chk_all("R6 carry cmd");
    end
    idle();

    // R7 R8 R9 R11: mask, pending, trap
    set_m = 1'b1; cyc(); idle();
    irq_req = 1'b1; cyc(); idle();
    chk_all("R8 held while masked");
    chk("R8 no forward", {7'd0, irq_out}, 8'h00);
    trap_req = 1'b1; cyc();
    chk("R9 trap bypass", {7'd0, irq_out}, 8'h01);
    idle();
    clr_m = 1'b1; set_m = 1'b1; cyc(); idle();
    chk_all("R7 set wins");
    clr_m = 1'b1; cyc(); idle();
    chk("R8 forwarded", {6'd0, irq_pending, irq_out}, 8'h03);
    chk_all("R7 clear");
    irq_enter = 1'b1; irq_req = 1'b1; clr_m = 1'b1; cyc(); idle();
    chk("R11 ack clears", {6'd0, irq_pending, irq_out}, 8'h00);
    chk("R7 enter masks", {7'd0, flag_i}, 8'h01);
    chk_all("R7 R11 state");

    // R10: pop load wins over all sources
    for (int v = 0; v < 32; v++) begin
      pop_load = 1'b1; pop_data = {v[2:0], v[4:0]};
      irq_enter = v[0]; set_c = v[1]; clr_m = v[2];
      op_cls = 3'd1; alu_res = 8'h80; alu_cout = 1'b1; alu_hc = 1'b1;
      cyc();
      chk("R10 pop load", ccr_q, {3'b111, v[4:0]});
      chk_all("R10 state");
    end
    idle();

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] rv;
      rv = $urandom;
      op_cls = rv[2:0]; alu_res = rv[10:3]; alu_cout = rv[11]; alu_hc = rv[12];
      set_c = (rv[15:13] == 0); clr_c = (rv[18:16] == 0);
      set_m = (rv[21:19] == 0); clr_m = (rv[23:22] == 0);
      irq_enter = (rv[26:24] == 0); pop_load = (rv[29:27] == 0);
      pop_data = $urandom; irq_req = rv[30]; trap_req = (rv[31] && rv[0]);
      cyc();
      chk_all("R3 R5 R7 R8 R10 random");
    end
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule